// File: doc/BRIEF.md
# 8-bit Shift and Status-Flag Unit

This block is the shift and flag slice of a small 8-bit microcontroller datapath. In one clock cycle it shifts, rotates or nibble-swaps a single register operand. It also holds the 8-bit status register, which it updates from the shift result. The same unit can set or clear any one status flag selected by an index. It can copy a chosen operand bit into the T flag, or write T into a chosen bit of the result.

The result and its write-enable are combinational from the current inputs and the current status. The status register is updated at the rising clock edge when the clock enable is high. The surrounding core decodes instructions and supplies the operand from its register file. It writes the result back whenever the write-enable is high.

Top module: `shift_flag_unit`

## Requirements
- R1: With `en` low, `result_we` is low and `status` holds its value across the clock edge.
- R2: Opcode 1 (shift left) gives the operand shifted up one place with 0 in bit 0, and the next C equals the old operand bit 7.
- R3: Opcode 2 (logical shift right) gives the operand shifted down one place with 0 in bit 7, and the next C equals the old operand bit 0.
- R4: Opcode 3 (rotate left via carry) puts the old C into bit 0, and the next C equals the old operand bit 7.
- R5: Opcode 4 (rotate right via carry) puts the old C into bit 7, and the next C equals the old operand bit 0.
- R6: Opcode 5 (arithmetic shift right) shifts bits 7..1 down one place and keeps bit 7, and the next C equals the old operand bit 0.
- R7: For opcodes 1 to 5 the following apply:
  - Z (status bit 1) is set exactly when the result is zero.
  - N (bit 2) equals result bit 7.
  - V (bit 3) equals N xor C.
  - S (bit 4) equals N xor V.
  - H (bit 5), T (bit 6) and I (bit 7) are unchanged.
  - `result_we` is high.
- R8: Opcode 6 (nibble swap) exchanges bits 7..4 with bits 3..0, raises `result_we` and leaves all of `status` unchanged.
- R9: Opcode 7 writes 1 and opcode 8 writes 0 into the status bit selected by `bit_sel`, and leave the other seven bits unchanged. The status bit order is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. `result_we` is low for both opcodes.
- R10: Opcode 9 copies operand bit `bit_sel` into T (status bit 6), changes no other status bit and keeps `result_we` low.
- R11: Opcode 10 returns the operand with bit `bit_sel` replaced by T, raises `result_we` and leaves `status` unchanged.
- R12: A synchronous active-high `rst` clears `status` to 0x00. Opcodes 0 and 11 to 15 keep `result_we` low and leave `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable; the operation takes effect only when high |
| op | input | 4 | Operation code (0 to 15) |
| operand | input | 8 | Register operand |
| bit_sel | input | 3 | Bit index for flag and T-bit operations |
| result | output | 8 | Operation result (combinational) |
| result_we | output | 1 | High when `result` must be written back |
| status | output | 8 | Status register |

## Verification
On every cycle, the in-line assertions check several behaviours. The status register holds while the unit is idle and through a nibble swap. The carry after a left shift matches the departing operand bit. A flag set or clear lands on the indexed bit. No write-enable appears for flag-only operations. Reset clears the status register. Only the bench's scenarios show that rotates really pass the old carry through, with carry preset both ways over every operand value. They also show the derived V and S flags and the T transfers at each bit index. Finally, they show that the result and flags follow a sequence of operations whose status depends on earlier ones.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    localparam int DW    = 8;
    localparam int HALF  = DW / 2;
    localparam int IDX_W = $clog2(DW);

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_SHL  = 4'd1,
        OP_SHR  = 4'd2,
        OP_ROL  = 4'd3,
        OP_ROR  = 4'd4,
        OP_ASR  = 4'd5,
        OP_SWAP = 4'd6,
        OP_FSET = 4'd7,
        OP_FCLR = 4'd8,
        OP_TST  = 4'd9,
        OP_TLD  = 4'd10
    } sfu_op_e;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          cout;
    } shift_out_t;

    function automatic logic is_shift(input sfu_op_e o);
        return (o == OP_SHL) || (o == OP_SHR) || (o == OP_ROL) ||
               (o == OP_ROR) || (o == OP_ASR);
    endfunction

endpackage

// File: rtl/sfu_shifter.sv
module sfu_shifter
    import sfu_pkg::*;
(
    input  sfu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic          cin,
    output shift_out_t    q
);
    always_comb begin
        q.data = a;
        q.cout = cin;
        case (op)
            OP_SHL:  begin q.data = {a[DW-2:0], 1'b0};     q.cout = a[DW-1]; end
            OP_SHR:  begin q.data = {1'b0, a[DW-1:1]};     q.cout = a[0];    end
            OP_ROL:  begin q.data = {a[DW-2:0], cin};      q.cout = a[DW-1]; end
            OP_ROR:  begin q.data = {cin, a[DW-1:1]};      q.cout = a[0];    end
            OP_ASR:  begin q.data = {a[DW-1], a[DW-1:1]};  q.cout = a[0];    end
            OP_SWAP: q.data = {a[HALF-1:0], a[DW-1:HALF]};
            default: ;
        endcase
    end
endmodule

// File: rtl/sfu_tmove.sv
module sfu_tmove
    import sfu_pkg::*;
(
    input  logic [DW-1:0]    a,
    input  logic [IDX_W-1:0] sel,
    input  logic             t_in,
    output logic [DW-1:0]    y,
    output logic             t_out
);
    assign t_out = a[sel];

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign y[i] = (sel == IDX_W'(i)) ? t_in : a[i];
    end
endmodule

// File: rtl/sfu_status.sv
module sfu_status
    import sfu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  sfu_op_e          op,
    input  logic [IDX_W-1:0] sel,
    input  logic [DW-1:0]    a,
    input  shift_out_t       sh,
    input  logic             t_bit,
    output logic [DW-1:0]    status
);
    logic [DW-1:0] nxt;
    logic          n_f, v_f;

    assign n_f = sh.data[DW-1];
    assign v_f = n_f ^ sh.cout;

    always_comb begin
        nxt = status;
        if (is_shift(op)) begin
            nxt[FL_C] = sh.cout;
            nxt[FL_Z] = (sh.data == '0);
            nxt[FL_N] = n_f;
            nxt[FL_V] = v_f;
            nxt[FL_S] = n_f ^ v_f;
        end else begin
            case (op)
                OP_FSET: nxt[sel]  = 1'b1;
                OP_FCLR: nxt[sel]  = 1'b0;
                OP_TST:  nxt[FL_T] = t_bit;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     status <= '0;
        else if (en) status <= nxt;
    end

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(status));

    p_shl_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (en && op == OP_SHL) |=> status[FL_C] == $past(a[DW-1]));

    p_swap_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (en && op == OP_SWAP) |=> $stable(status));

    p_fset_index_r9: assert property (@(posedge clk) disable iff (rst)
        (en && op == OP_FSET) |=> status[$past(sel)] == 1'b1);

    p_fclr_index_r9: assert property (@(posedge clk) disable iff (rst)
        (en && op == OP_FCLR) |=> status[$past(sel)] == 1'b0);

    p_tld_flags_r11: assert property (@(posedge clk) disable iff (rst)
        (en && op == OP_TLD) |=> $stable(status));

    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> status == '0);
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
    import sfu_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [3:0]   op,
    input  logic [7:0]   operand,
    input  logic [2:0]   bit_sel,
    output logic [7:0]   result,
    output logic         result_we,
    output logic [7:0]   status
);
    sfu_op_e    op_e;
    shift_out_t sh;
    logic [DW-1:0] tm_y;
    logic          t_bit;

    assign op_e = sfu_op_e'(op);

    sfu_shifter u_shift (
        .op  (op_e),
        .a   (operand),
        .cin (status[FL_C]),
        .q   (sh)
    );

    sfu_tmove u_tmove (
        .a     (operand),
        .sel   (bit_sel),
        .t_in  (status[FL_T]),
        .y     (tm_y),
        .t_out (t_bit)
    );

    sfu_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .op     (op_e),
        .sel    (bit_sel),
        .a      (operand),
        .sh     (sh),
        .t_bit  (t_bit),
        .status (status)
    );

    always_comb begin
        result    = operand;
        result_we = 1'b0;
        if (is_shift(op_e) || op_e == OP_SWAP) begin
            result    = sh.data;
            result_we = en;
        end else if (op_e == OP_TLD) begin
            result    = tm_y;
            result_we = en;
        end
    end

    always_comb begin
        if (en && (op_e == OP_FSET || op_e == OP_FCLR || op_e == OP_TST))
            p_no_write_r9: assert (!result_we);
        if (en && op_e == OP_SWAP)
            p_swap_nibbles_r8: assert (result == {operand[3:0], operand[7:4]});
    end
endmodule

// File: tb/sim_shift_flag_unit.sv
module sim_shift_flag_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [3:0] op;
    logic [7:0] operand;
    logic [2:0] bit_sel;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] status;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] mstat;

    always #5 clk = ~clk;

    shift_flag_unit u0 (
        .clk(clk), .rst(rst), .en(en), .op(op), .operand(operand),
        .bit_sel(bit_sel), .result(result), .result_we(result_we), .status(status)
    );

    // {op, operand, bit_sel, exp_result, exp_we, exp_status}, run from status 0x00
    localparam logic [31:0] VEC [0:11] = '{
        {4'd7,  8'h00, 3'd0, 8'h00, 1'b0, 8'h01},
        {4'd3,  8'h80, 3'd0, 8'h01, 1'b1, 8'h19},
        {4'd6,  8'h3C, 3'd0, 8'hC3, 1'b1, 8'h19},
        {4'd7,  8'h00, 3'd6, 8'h00, 1'b0, 8'h59},
        {4'd10, 8'h00, 3'd5, 8'h20, 1'b1, 8'h59},
        {4'd2,  8'h01, 3'd0, 8'h00, 1'b1, 8'h5B},
        {4'd8,  8'h00, 3'd6, 8'h00, 1'b0, 8'h1B},
        {4'd9,  8'h80, 3'd7, 8'h00, 1'b0, 8'h5B},
        {4'd5,  8'h81, 3'd0, 8'hC0, 1'b1, 8'h55},
        {4'd4,  8'h00, 3'd0, 8'h80, 1'b1, 8'h4C},
        {4'd15, 8'hFF, 3'd0, 8'h00, 1'b0, 8'h4C},
        {4'd1,  8'h00, 3'd0, 8'h00, 1'b1, 8'h42}
    };

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd1: return "R2";  4'd2: return "R3";  4'd3: return "R4";
            4'd4: return "R5";  4'd5: return "R6";  4'd6: return "R8";
            4'd7, 4'd8: return "R9";
            4'd9: return "R10"; 4'd10: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", rq, what, act, exp);
        end
    endtask

    // Independent reference model
    task automatic model(input logic [3:0] o, input logic [7:0] v, input logic [2:0] s,
                         input logic [7:0] st, output logic [7:0] r, output logic w,
                         output logic [7:0] ns);
        logic c, n, vf;
        r = v; w = 1'b0; ns = st; c = st[0];
        case (o)
            4'd1: begin r = v << 1;              c = v[7]; end
            4'd2: begin r = v >> 1;              c = v[0]; end
            4'd3: begin r = {v[6:0], st[0]};     c = v[7]; end
            4'd4: begin r = {st[0], v[7:1]};     c = v[0]; end
            4'd5: begin r = {v[7], v[7:1]};      c = v[0]; end
            4'd6: begin r = {v[3:0], v[7:4]};    w = 1'b1; end
            4'd7: ns[s] = 1'b1;
            4'd8: ns[s] = 1'b0;
            4'd9: ns[6] = v[s];
            4'd10: begin r[s] = st[6]; w = 1'b1; end
            default: ;
        endcase
        if (o >= 4'd1 && o <= 4'd5) begin
            // R7 derived flags
            w = 1'b1;
            n = r[7];
            vf = n ^ c;
            ns[4:0] = {n ^ vf, vf, n, (r == 8'h00), c};
        end
    endtask

    task automatic step(input logic [3:0] o, input logic [7:0] v, input logic [2:0] s,
                        output logic [7:0] r_act, output logic w_act);
        @(negedge clk);
        op = o; operand = v; bit_sel = s; en = 1'b1;
        #1;
        r_act = result; w_act = result_we;
        @(posedge clk);
        #1 en = 1'b0;
    endtask

    task automatic run_model(input logic [3:0] o, input logic [7:0] v, input logic [2:0] s);
        logic [7:0] r_act, r_exp, ns;
        logic w_act, w_exp;
        string rq;
        model(o, v, s, mstat, r_exp, w_exp, ns);
        rq = req_of(o);
        step(o, v, s, r_act, w_act);
        check(rq, "result_we", {7'd0, w_act}, {7'd0, w_exp});
        if (w_exp) check(rq, "result", r_act, r_exp);
        check((o >= 4'd1 && o <= 4'd5) ? "R7" : rq, "status", status, ns);
        mstat = ns;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r_act, hold;
        logic w_act;
        rst = 1'b1; en = 1'b0; op = '0; operand = '0; bit_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12", "reset status", status, 8'h00);
        rst = 1'b0;

        // Vector table walk
        for (int i = 0; i < 12; i++) begin
            logic [31:0] e;
            e = VEC[i];
            step(e[31:28], e[27:20], e[19:17], r_act, w_act);
            check(req_of(e[31:28]), "table we", {7'd0, w_act}, {7'd0, e[8]});
            if (e[8]) check(req_of(e[31:28]), "table result", r_act, e[16:9]);
            check(req_of(e[31:28]), "table status", status, e[7:0]);
        end
        mstat = 8'h42;

        // R1: enable low, shift-left of 0xFF must do nothing
        @(negedge clk);
        op = 4'd1; operand = 8'hFF; bit_sel = 3'd0; en = 1'b0;
        #1 check("R1", "we when idle", {7'd0, result_we}, 8'h00);
        hold = status;
        @(posedge clk);
        #1 check("R1", "status when idle", status, hold);

        // Exhaustive shifts, rotates and swap with carry 0 and 1
        for (int o = 1; o <= 6; o++)
            for (int c = 0; c < 2; c++)
                for (int v = 0; v < 256; v++) begin
                    run_model(c ? 4'd7 : 4'd8, 8'h00, 3'd0);
                    run_model(4'(o), 8'(v), 3'd0);
                end

        // Flag set/clear at each index, T store/load at each bit
        for (int s = 0; s < 8; s++) begin
            run_model(4'd7, 8'h00, 3'(s));
            run_model(4'd8, 8'hFF, 3'(s));
            for (int k = 0; k < 4; k++) begin
                logic [7:0] pat;
                pat = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'(1 << s);
                run_model(4'd9, pat, 3'(s));
                run_model(4'd10, ~pat, 3'(s));
                run_model(4'd10, pat, 3'(s));
            end
        end

        // R12: reserved codes do nothing
        for (int o = 11; o < 16; o++) run_model(4'(o), 8'hFF, 3'd7);
        run_model(4'd0, 8'h55, 3'd3);

        // R12: reset mid-run
        run_model(4'd7, 8'h00, 3'd7);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        check("R12", "status after reset", status, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule